// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Controller

This block keeps an asynchronous DRAM array alive. After reset it holds the memory idle for a programmable power-up pause. It then runs a fixed burst of CAS-before-RAS refresh cycles and raises a ready flag, and from then on it schedules one refresh per refresh interval. Every refresh is either CAS-before-RAS, where the DRAM supplies its own row, or RAS-only, where the block drives a row number from its own wrapping counter.

The block shares the RAS, CAS and WE strobes with the access sequencer. When a refresh is owed it raises a request and waits for a grant. It drives the strobes and the row address only while it owns the bus, and it releases them when it is done. Intervals that pass while the access side holds the bus are kept as a small saturating debt. The whole debt is then paid back to back inside one grant.

All timing parameters are in clock cycles. A refresh cycle is a setup phase of `T_SETUP` cycles (RAS high, CAS low for CAS-before-RAS), then a RAS-low phase of `T_RAS` cycles, then a precharge of `T_RP` cycles with all strobes high.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During reset and right after it, `ras_n`, `cas_n` and `we_n` are 1, `strobe_oe`, `addr_oe`, `bus_req` and `init_done` are 0, and `row_addr` is 0.
- R2: `bus_req` stays 0 for the first `INIT_WAIT - 1` clock edges after reset release and is 1 after edge `INIT_WAIT`.
- R3: The power-up burst is exactly `INIT_CYCLES` CAS-before-RAS cycles, even when `ras_only_mode` is 1. `init_done` becomes 1 `INIT_CYCLES*(T_SETUP+T_RAS+T_RP)` edges after the first edge at which the grant is sampled high, and the request drops at the same time.
- R4: In a CAS-before-RAS cycle, CAS is low in the cycle before RAS falls and stays low while RAS is low. WE is high throughout. RAS is low for at least `T_RAS` cycles and high for at least `T_RP` cycles before each fall.
- R5: While `bus_req` is 1 and no grant has been sampled, `strobe_oe` is 0 and the strobes stay high. `strobe_oe` is 1 only while `bus_req` is 1. With strobes released, RAS and CAS read high.
- R6: After `init_done` rises, `bus_req` rises again `REF_INTERVAL + 1` edges later. A single owed refresh ends with `bus_req` dropping `T_SETUP+T_RAS+T_RP` edges after the grant is sampled.
- R7: Intervals that expire without a grant are counted up to `DEBT_MAX`. Further expiries are dropped. On grant, exactly the counted number of cycles runs back to back, and the request drops after the last one.
- R8: A RAS-only cycle keeps CAS high the whole time. It drives `addr_oe` = 1 during setup and RAS low, and presents the row counter on `row_addr`.
- R9: The row counter starts at 0 and steps by one after each RAS-only cycle, wrapping from all ones to 0. CAS-before-RAS cycles leave it unchanged.
- R10: Once `init_done` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh after power-up, 0 selects CAS-before-RAS; sampled as each cycle starts |
| bus_gnt | input | 1 | Grant from the arbiter; must stay high while `bus_req` is high once given |
| bus_req | output | 1 | Request for the strobe bus |
| strobe_oe | output | 1 | Drive enable for the RAS, CAS and WE pads |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| addr_oe | output | 1 | Drive enable for the row address pads |
| row_addr | output | ROW_W | Row number for RAS-only refresh |
| init_done | output | 1 | High once the power-up burst has completed |

## Verification
The request appears `INIT_WAIT` edges after reset release, and `REF_INTERVAL + 1` edges after each interval starts counting. Each owed refresh adds `T_SETUP+T_RAS+T_RP` edges after the first edge at which the grant is sampled. The bench counts edges from a known point and compares each count with that exact number. It drives the grant and the mode bits one step after a rising edge, so every sample sits between edges. A separate monitor sampling at falling edges classifies each RAS fall by the CAS level and logs the row, so the cycle shape and the row sequence are checked at the pins.

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int INIT_WAIT    = 25000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 800,
  parameter int DEBT_MAX     = 4,
  parameter int T_SETUP      = 1,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 3,
  parameter int ROW_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_mode,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             strobe_oe,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             init_done
);

  localparam int PW   = $clog2(INIT_WAIT + 1);
  localparam int TW   = $clog2(REF_INTERVAL + 1);
  localparam int DW   = $clog2(DEBT_MAX + 1);
  localparam int IW   = $clog2(INIT_CYCLES + 1);
  localparam int PM1  = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int PMAX = (PM1 > T_SETUP) ? PM1 : T_SETUP;
  localparam int PHW  = (PMAX > 1) ? $clog2(PMAX) : 1;

  localparam logic [PW-1:0]  PAUSE_END = PW'(INIT_WAIT - 1);
  localparam logic [TW-1:0]  TMR_END   = TW'(REF_INTERVAL - 1);
  localparam logic [DW-1:0]  DEBT_TOP  = DW'(DEBT_MAX);
  localparam logic [IW-1:0]  INIT_N    = IW'(INIT_CYCLES);
  localparam logic [IW-1:0]  INIT_LAST = IW'(1);
  localparam logic [PHW-1:0] SET_END   = PHW'(T_SETUP - 1);
  localparam logic [PHW-1:0] LOW_END   = PHW'(T_RAS - 1);
  localparam logic [PHW-1:0] PRE_END   = PHW'(T_RP - 1);

  typedef enum logic [2:0] {ST_PAUSE, ST_IDLE, ST_WAIT, ST_SETUP, ST_LOW, ST_PRE} st_t;

  st_t             st;
  logic [PW-1:0]   pause_q;
  logic [TW-1:0]   tmr_q;
  logic [DW-1:0]   debt_q, debt_d;
  logic [IW-1:0]   init_left;
  logic [PHW-1:0]  ph;
  logic            ror_q;
  logic [ROW_W-1:0] row_q;

  wire tick  = init_done && (tmr_q == TMR_END);
  wire done  = (st == ST_PRE) && (ph == PRE_END);
  wire more  = init_done ? (debt_d != '0) : (init_left != INIT_LAST);
  wire pick  = init_done && ras_only_mode;

  always_comb begin
    debt_d = debt_q;
    if (done && init_done && debt_d != '0) debt_d = debt_d - 1'b1;
    if (tick && debt_d != DEBT_TOP)        debt_d = debt_d + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      pause_q   <= '0;
      tmr_q     <= '0;
      debt_q    <= '0;
      init_left <= INIT_N;
      ph        <= '0;
      ror_q     <= 1'b0;
      row_q     <= '0;
      init_done <= 1'b0;
    end else begin
      debt_q <= debt_d;
      if (init_done) tmr_q <= tick ? '0 : tmr_q + 1'b1;
      case (st)
        ST_PAUSE:
          if (pause_q == PAUSE_END) st <= ST_WAIT;
          else pause_q <= pause_q + 1'b1;
        ST_IDLE:
          if (debt_q != '0) st <= ST_WAIT;
        ST_WAIT:
          if (bus_gnt) begin
            st    <= ST_SETUP;
            ph    <= '0;
            ror_q <= pick;
          end
        ST_SETUP:
          if (ph == SET_END) begin
            st <= ST_LOW;
            ph <= '0;
          end else ph <= ph + 1'b1;
        ST_LOW:
          if (ph == LOW_END) begin
            st <= ST_PRE;
            ph <= '0;
          end else ph <= ph + 1'b1;
        ST_PRE:
          if (done) begin
            ph <= '0;
            if (ror_q) row_q <= row_q + 1'b1;
            if (!init_done) begin
              init_left <= init_left - 1'b1;
              if (init_left == INIT_LAST) init_done <= 1'b1;
            end
            if (more) begin
              st    <= bus_gnt ? ST_SETUP : ST_WAIT;
              ror_q <= pick;
            end else begin
              st <= ST_IDLE;
            end
          end else ph <= ph + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  wire front = (st == ST_SETUP) || (st == ST_LOW);

  assign bus_req   = (st == ST_WAIT) || (st == ST_SETUP) || (st == ST_LOW) || (st == ST_PRE);
  assign strobe_oe = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_PRE);
  assign ras_n     = (st != ST_LOW);
  assign cas_n     = !(front && !ror_q);
  assign we_n      = 1'b1;
  assign addr_oe   = front && ror_q;
  assign row_addr  = row_q;

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int T_RAS = 3,
  parameter int T_RP  = 3,
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             strobe_oe,
  input logic             ras_n,
  input logic             cas_n,
  input logic             addr_oe,
  input logic [ROW_W-1:0] row_addr,
  input logic             init_done
);

  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n ? 8'd0 : ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 8'd1);
      hi_cnt <= !ras_n ? 8'd0 : ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 8'd1);
    end
  end

  // R4
  ras_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= 8'(T_RAS)));

  // R4
  precharge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));

  // R4
  cbr_cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R8
  ror_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> cas_n);

  // R5
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_oe |-> bus_req);

  // R5
  released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_oe |-> (ras_n && cas_n));

  // R3
  init_is_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !addr_oe);

  // R10
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R9
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(
  .T_RAS(T_RAS), .T_RP(T_RP), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .strobe_oe(strobe_oe),
  .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr),
  .init_done(init_done)
);

// File: tb/tb_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_dram_refresh_ctrl;
  localparam int IWAIT = 40;
  localparam int ICYC  = 8;
  localparam int RI    = 60;
  localparam int DM    = 3;
  localparam int TS    = 1;
  localparam int TR    = 3;
  localparam int TP    = 3;
  localparam int RW    = 4;
  localparam int CYC   = TS + TR + TP;

  logic clk = 0, rst_n = 0, mode = 0, bus_gnt = 0, allow = 0;
  logic bus_req, strobe_oe, ras_n, cas_n, we_n, addr_oe, init_done;
  logic [RW-1:0] row_addr;
  int total = 0, bad = 0, cyc = 0;
  int cbr_n = 0, ror_n = 0, cbr_bad = 0, ror_cas_bad = 0, last_row = 0, last_aoe = 0;
  logic prev_ras = 1, prev_cas = 1;
  bit fin = 0;

  dram_refresh_ctrl #(.INIT_WAIT(IWAIT), .INIT_CYCLES(ICYC), .REF_INTERVAL(RI),
    .DEBT_MAX(DM), .T_SETUP(TS), .T_RAS(TR), .T_RP(TP), .ROW_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .strobe_oe(strobe_oe), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr_oe(addr_oe), .row_addr(row_addr), .init_done(init_done));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) bus_gnt = allow && bus_req;

  always @(negedge clk) begin
    if (prev_ras && !ras_n) begin
      if (!cas_n) begin
        cbr_n++;
        if (prev_cas || !we_n) cbr_bad++;
      end else ror_n++;
      last_row = int'(row_addr);
      last_aoe = int'(addr_oe);
    end
    if (addr_oe && !cas_n) ror_cas_bad++;
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; allow = 0; mode = 1;
    repeat (3) step();
    chk("R1 strobes high", int'({ras_n, cas_n, we_n}), 7);
    chk("R1 outputs low", int'({strobe_oe, addr_oe, bus_req, init_done}), 0);
    chk("R1 row zero", int'(row_addr), 0);
    rst_n = 1;
    repeat (IWAIT - 1) step();
    chk("R2 no request during pause", int'(bus_req), 0);
    step();
    chk("R2 request after pause", int'(bus_req), 1);
  endtask

  task automatic t_wait_gnt();
    int viol = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (!bus_req || strobe_oe || !ras_n || !cas_n) viol++;
    end
    chk("R5 released while ungranted", viol, 0);
  endtask

  task automatic t_init();
    int n = 0, c0 = cbr_n, r0 = ror_n;
    allow = 1;
    while (!init_done) begin step(); n++; end
    chk("R3 init latency", n, ICYC * CYC + 1);
    chk("R3 init cbr count", cbr_n - c0, ICYC);
    chk("R3 no ras-only during init", ror_n - r0, 0);
    chk("R3 request dropped", int'(bus_req), 0);
    chk("R4 cbr shape", cbr_bad, 0);
  endtask

  task automatic t_periodic();
    int n = 0, c0 = cbr_n;
    mode = 0;
    while (!bus_req) begin step(); n++; end
    chk("R6 interval latency", n, RI + 1);
    n = 0;
    while (bus_req) begin step(); n++; end
    chk("R6 single refresh span", n, CYC + 1);
    chk("R6 one cbr done", cbr_n - c0, 1);
  endtask

  task automatic t_debt();
    int n = 0, c0, viol = 0;
    allow = 0;
    for (int i = 0; i < 5 * RI; i++) begin
      step();
      if (strobe_oe) viol++;
    end
    chk("R5 no drive while postponed", viol, 0);
    c0 = cbr_n;
    allow = 1;
    while (bus_req) begin step(); n++; end
    chk("R7 back to back span", n, DM * CYC + 1);
    chk("R7 debt capped", cbr_n - c0, DM);
    repeat (10) step();
    chk("R7 excess dropped", int'(bus_req), 0);
  endtask

  task automatic t_ror();
    for (int i = 0; i < (1 << RW) + 2; i++) begin
      int r0 = ror_n;
      while (ror_n == r0) step();
      chk($sformatf("R9 row seq %0d", i), last_row, i % (1 << RW));
      chk("R8 addr driven", last_aoe, 1);
    end
    chk("R8 cas high in ras-only", ror_cas_bad, 0);
  endtask

  task automatic t_cbr_row();
    int c0;
    while (bus_req) step();
    c0 = cbr_n;
    mode = 0;
    while (cbr_n == c0) step();
    while (bus_req) step();
    chk("R9 cbr leaves row", int'(row_addr), ((1 << RW) + 2) % (1 << RW));
    chk("R10 init_done held", int'(init_done), 1);
    chk("R4 cbr shape final", cbr_bad, 0);
  endtask

  initial begin
    t_reset();
    t_wait_gnt();
    t_init();
    t_periodic();
    t_debt();
    mode = 1;
    t_ror();
    t_cbr_row();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0 cycles left", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule